// File: doc/BRIEF.md
# Single-Byte SPI Master with Completion Flag

This block is a serial peripheral master driven through a small register port. A host write to the data register loads the transmit shifter and starts the serial clock. The block then runs eight clock periods in mode 0 (SCK idles low, MOSI is updated while SCK is low, and MISO is captured on the rising edge). After the eighth bit the clock stops by itself. The block then sets a completion flag, raises an optional interrupt, and copies the received byte into a read buffer.

Only one byte is held for transmit. A data write that arrives while a byte is still shifting is dropped, and a collision status bit records it. Receive has two stages: the shifter and a separate read buffer. The buffer keeps the previous byte until the next transfer completes. The device-select line is a plain output that software sets through a control bit; transfers never change it. The serial clock rate comes from the `div_half` input, which gives the half period in system clocks. The value is captured when a transfer starts, so the SCK period is always an even number of system clocks, at least 2.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, sck=0, ssel_n=1 and irq=0. The status register (address 1) reads 0x00 and the control register (address 0) reads 0x02.
- R2: A write to the data register (address 2) while idle starts a transfer. Status bit 0 (busy) is 1 from the cycle after the write. Status bit 7 (done flag) is set exactly 16*H clock edges after the write edge, where H is the half-period value in use.
- R3: Bits leave MSB first on MOSI. MOSI holds steady while SCK is high, so a receiver sampling on the SCK rising edge sees the written byte.
- R4: The SCK period is 2*H system clocks. H is taken from div_half at the start write, and a value of 0 is treated as 1.
- R5: Each transfer produces exactly eight SCK rising edges, and SCK stays low whenever no transfer is active.
- R6: After the done flag is set, a read of address 2 returns the byte sampled from MISO, MSB first. This byte is kept unchanged until the next transfer completes.
- R7: A data write while busy is ignored, so the byte in flight and the receive buffer are unaffected. It also sets status bit 6 (write collision).
- R8: A status read (with reg_re) while the done flag is set, followed by a read or write of address 2, clears the done flag and the collision bit. An access to address 2 without that status read leaves the flag set.
- R9: irq equals the done flag gated by control bit 0 (interrupt enable).
- R10: ssel_n equals control bit 1 and is changed by nothing but control writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe, used for read side effects |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| div_half | input | DIVW | SCK half period in system clocks |
| miso | input | 1 | Serial data from the device |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| ssel_n | output | 1 | Software-driven device select |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter shows at once as a ninth or a missing SCK rising edge and as a done flag arriving a multiple of H cycles early or late. A broken shifter shows within one transfer as the byte a bus-side receiver sees, or as the byte read back from the buffer. Errors in the flag-clear and collision state show at the status register on the first access after the sequence that should have changed them. Errors in the divider latch show as a wrong gap between consecutive rising edges inside the transfer.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;
    localparam int CTRL_IE  = 0;
    localparam int CTRL_SEL = 1;
    localparam int ST_BUSY  = 0;
    localparam int ST_WCOL  = 6;
    localparam int ST_DONE  = 7;
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            run,
    input  logic [DIVW-1:0] half_in,
    output logic            tick
);
    localparam logic [DIVW-1:0] ONE = DIVW'(1);

    typedef struct packed {
        logic [DIVW-1:0] cnt;
        logic [DIVW-1:0] half;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (load) begin
            st_d.cnt  = '0;
            st_d.half = (half_in == '0) ? ONE : half_in;
        end else if (run) begin
            if (st_q.cnt == (st_q.half - ONE)) begin
                tick     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, half: ONE};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         tick,
    input  logic         miso,
    output logic         sck,
    output logic         mosi,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  tx_sr;
        logic [W-1:0]  rx_sr;
        logic [CW-1:0] bitcnt;
        logic          sck;
        logic          busy;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (start) begin
            st_d.tx_sr  = tx_byte;
            st_d.bitcnt = '0;
            st_d.sck    = 1'b0;
            st_d.busy   = 1'b1;
        end else if (st_q.busy && tick) begin
            if (!st_q.sck) begin
                st_d.sck   = 1'b1;
                st_d.rx_sr = {st_q.rx_sr[W-2:0], miso};
            end else begin
                st_d.sck = 1'b0;
                if (st_q.bitcnt == LAST) begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    st_d.bitcnt = st_q.bitcnt + CW'(1);
                    st_d.tx_sr  = {st_q.tx_sr[W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck     = st_q.sck;
    assign mosi    = st_q.tx_sr[W-1];
    assign busy    = st_q.busy;
    assign rx_byte = st_q.rx_sr;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_master_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIVW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DIVW-1:0]   div_half,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              ssel_n,
    output logic              irq
);
    typedef struct packed {
        logic              ie;
        logic              sel;
        logic              flag;
        logic              wcol;
        logic              arm;
        logic [DATA_W-1:0] rxbuf;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              eng_busy, eng_done, tick, start;
    logic [DATA_W-1:0] eng_rx;
    logic              wr_data, data_acc;
    logic              flag_w, wcol_w;

    assign wr_data  = reg_we && (reg_addr == ADR_DATA);
    assign data_acc = wr_data || (reg_re && (reg_addr == ADR_DATA));
    assign start    = wr_data && !eng_busy;

    spi_sck_div #(.DIVW(DIVW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .run    (eng_busy),
        .half_in(div_half),
        .tick   (tick)
    );

    spi_shift_engine #(.W(DATA_W)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .tx_byte(reg_wdata),
        .tick   (tick),
        .miso   (miso),
        .sck    (sck),
        .mosi   (mosi),
        .busy   (eng_busy),
        .done   (eng_done),
        .rx_byte(eng_rx)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we && (reg_addr == ADR_CTRL)) begin
            st_d.ie  = reg_wdata[CTRL_IE];
            st_d.sel = reg_wdata[CTRL_SEL];
        end
        if (reg_re && (reg_addr == ADR_STAT) && st_q.flag) begin
            st_d.arm = 1'b1;
        end
        if (st_q.arm && data_acc) begin
            st_d.flag = 1'b0;
            st_d.wcol = 1'b0;
            st_d.arm  = 1'b0;
        end
        if (wr_data && eng_busy) begin
            st_d.wcol = 1'b1;
        end
        if (eng_done) begin
            st_d.flag  = 1'b1;
            st_d.rxbuf = eng_rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ie: 1'b0, sel: 1'b1, flag: 1'b0, wcol: 1'b0,
                      arm: 1'b0, rxbuf: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[CTRL_IE]  = st_q.ie;
                reg_rdata[CTRL_SEL] = st_q.sel;
            end
            ADR_STAT: begin
                reg_rdata[ST_BUSY] = eng_busy;
                reg_rdata[ST_WCOL] = st_q.wcol;
                reg_rdata[ST_DONE] = st_q.flag;
            end
            ADR_DATA: reg_rdata = st_q.rxbuf;
            default:  reg_rdata = '0;
        endcase
    end

    assign flag_w = st_q.flag;
    assign wcol_w = st_q.wcol;
    assign ssel_n = st_q.sel;
    assign irq    = st_q.flag && st_q.ie;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
    import spi_master_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_addr,
    input logic       sck,
    input logic       mosi,
    input logic       ssel_n,
    input logic       busy,
    input logic       flag,
    input logic       wcol
);
    assert_sck_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    assert_mosi_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    assert_flag_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> flag);

    assert_wcol_on_busy_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == ADR_DATA) && busy) |=> wcol);

    assert_ssel_only_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && (reg_addr == ADR_CTRL)) |=> $stable(ssel_n));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .sck     (sck),
    .mosi    (mosi),
    .ssel_n  (ssel_n),
    .busy    (eng_busy),
    .flag    (flag_w),
    .wcol    (wcol_w)
);

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic [7:0] div_half = 8'd1;
    logic       miso, sck, mosi, ssel_n, irq;

    spi_byte_master uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .div_half(div_half), .miso(miso), .sck(sck), .mosi(mosi),
        .ssel_n(ssel_n), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    // device-side model: drives MISO from slv_tx, MSB first, shifted on SCK fall
    logic [7:0] slv_tx = 8'h00;
    int falls = 0, fbase = 0;
    logic [2:0] fidx;
    assign fidx = 3'(falls - fbase);
    assign miso = slv_tx[3'd7 - fidx];
    always @(negedge sck) falls = falls + 1;

    // scoreboard
    logic [7:0] exp_q[$];
    int n_chk = 0, n_fail = 0, mon_checks = 0, mon_fails = 0;
    int rises = 0, last_rise = 0, rise_gap = 0, mon_bits = 0;
    logic [7:0] mon_sr = 8'h00;

    always @(posedge sck) begin
        mon_sr = {mon_sr[6:0], mosi};
        rises = rises + 1;
        rise_gap = cyc - last_rise;
        last_rise = cyc;
        mon_bits = mon_bits + 1;
        if (mon_bits == 8) begin
            logic [7:0] e;
            mon_bits = 0;
            mon_checks = mon_checks + 1;
            if (exp_q.size() == 0) begin
                mon_fails = mon_fails + 1;
                $display("FAIL R3 unexpected byte on MOSI: got %02h expected none", mon_sr);
            end else begin
                e = exp_q.pop_front();
                if (mon_sr != e) begin
                    mon_fails = mon_fails + 1;
                    $display("FAIL R3 MOSI byte: got %02h expected %02h", mon_sr, e);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a; reg_re = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_re = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic start_x(input logic [7:0] tx, input logic [7:0] sb, input logic [7:0] h);
        logic [7:0] s;
        div_half = h; slv_tx = sb; fbase = falls;
        exp_q.push_back(tx);
        wr(2'd2, tx);
        peek(2'd1, s);
        chk(s[0] == 1'b1, "R2 busy after start", s[0], 1);
    endtask

    task automatic wait_done(output int n);
        logic [7:0] s;
        n = 0;
        forever begin
            peek(2'd1, s);
            if (s[7]) break;
            @(negedge clk);
            n = n + 1;
            if (n > 50000) begin
                chk(1'b0, "R2 flag never set", n, 0);
                break;
            end
        end
    endtask

    task automatic clear_flag(input logic [7:0] exp_rx);
        logic [7:0] s, v;
        rd(2'd1, s);
        rd(2'd2, v);
        chk(v == exp_rx, "R6 received byte", v, exp_rx);
        peek(2'd1, s);
        chk(s == 8'h00, "R8 status after clear", s, 0);
    endtask

    initial begin
        int n, r0;
        logic [7:0] s, v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(ssel_n == 1'b1, "R1 ssel_n", ssel_n, 1);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        peek(2'd1, s); chk(s == 8'h00, "R1 status", s, 0);
        peek(2'd0, s); chk(s == 8'h02, "R1 control", s, 2);

        // R2 R3 R5 R6: H=1
        r0 = rises;
        start_x(8'hA5, 8'h3C, 8'd1);
        wait_done(n);
        chk(n == 16, "R2 done latency H=1", n, 16);
        chk(rises - r0 == 8, "R5 rising edges", rises - r0, 8);
        repeat (4) @(negedge clk);
        chk(sck == 1'b0, "R5 sck idle after transfer", sck, 0);
        clear_flag(8'h3C);

        // R4: H=3, period 6
        r0 = rises;
        start_x(8'h81, 8'hC3, 8'd3);
        wait_done(n);
        chk(n == 48, "R2 done latency H=3", n, 48);
        chk(rise_gap == 6, "R4 SCK period H=3", rise_gap, 6);
        chk(rises - r0 == 8, "R5 rising edges H=3", rises - r0, 8);
        clear_flag(8'hC3);

        // R4: H=0 behaves as 1
        start_x(8'h6E, 8'h17, 8'd0);
        wait_done(n);
        chk(n == 16, "R4 H=0 latency", n, 16);
        clear_flag(8'h17);

        // R7 collision, R6 double buffer
        start_x(8'h55, 8'hE1, 8'd2);
        repeat (5) @(negedge clk);
        peek(2'd2, v);
        chk(v == 8'h17, "R6 old byte held during transfer", v, 8'h17);
        div_half = 8'd1;
        wr(2'd2, 8'hFF);
        peek(2'd1, s);
        chk(s[6] == 1'b1, "R7 collision bit", s[6], 1);
        wait_done(n);
        clear_flag(8'hE1);

        // R8 no clear without status read
        start_x(8'h12, 8'h34, 8'd1);
        wait_done(n);
        rd(2'd2, v);
        peek(2'd1, s);
        chk(s[7] == 1'b1, "R8 flag kept without status read", s[7], 1);
        clear_flag(8'h34);

        // R9 interrupt gating, R10 select output
        wr(2'd0, 8'h01);
        chk(ssel_n == 1'b0, "R10 ssel_n low", ssel_n, 0);
        start_x(8'hF0, 8'h0F, 8'd2);
        repeat (10) @(negedge clk);
        chk(ssel_n == 1'b0, "R10 ssel_n held in transfer", ssel_n, 0);
        chk(irq == 1'b0, "R9 irq while busy", irq, 0);
        wait_done(n);
        chk(irq == 1'b1, "R9 irq with enable", irq, 1);
        wr(2'd0, 8'h02);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        chk(ssel_n == 1'b1, "R10 ssel_n high", ssel_n, 1);
        peek(2'd1, s);
        chk(s[7] == 1'b1, "R9 flag still set when masked", s[7], 1);
        clear_flag(8'h0F);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R7 bytes outstanding", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==",
                 n_chk + mon_checks, n_fail + mon_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==",
                 n_chk + mon_checks + 1, n_fail + mon_fails + 1);
        $finish;
    end
endmodule